// File: doc/BRIEF.md
# Function-Selected Arithmetic/Logic Unit with Status Outputs

This block applies one of six operations to two unsigned operands of a parameterised width. A 3-bit function code chooses the operation: addition, subtraction, decrement, bitwise AND, bitwise OR, or bitwise inversion. The two remaining codes are unused and produce a zero result. Along with the result, the block drives three status outputs: a carry/borrow bit, a flag that is set when the result is zero, and an unsigned comparison that is set when the first operand is greater than the second. These outputs feed flag-update logic elsewhere. The block does not hold any flags of its own.

A small decoder turns the function code into a struct of datapath strobes. The datapath has a single adder that serves all three arithmetic operations, and a per-bit logic slice for the bitwise operations. The parameter `REG_OUT` chooses the output timing. When it is 1, all four outputs are registered and appear one clock after the inputs. When it is 0, the outputs follow the inputs combinationally.

Top module: `aluTop`

## Requirements
- R1: Function code 3'b000 gives result = (opA + opB) mod 2^WIDTH, and carryOut is the carry out of the most significant bit.
- R2: Function code 3'b001 gives result = (opA - opB) mod 2^WIDTH, and carryOut is 1 exactly when opB > opA (unsigned borrow).
- R3: Function code 3'b010 gives result = (opA - 1) mod 2^WIDTH, and carryOut is 1 exactly when opA is 0.
- R4: Function code 3'b011 gives result = opA AND opB, bit by bit.
- R5: Function code 3'b100 gives result = opA OR opB, bit by bit.
- R6: Function code 3'b101 gives result = NOT opA, bit by bit.
- R7: Function codes 3'b110 and 3'b111 give result = 0 and carryOut = 0, with zeroOut set.
- R8: For function codes 3'b011, 3'b100 and 3'b101, carryOut is 0.
- R9: zeroOut is 1 exactly when the result it accompanies is all zeros.
- R10: aGreater is 1 exactly when opA > opB as unsigned numbers, for every function code.
- R11: With REG_OUT = 1, each output reflects the inputs sampled at the previous rising clock edge. While rstN is low, the outputs are result = 0, carryOut = 0, zeroOut = 1 and aGreater = 0. With REG_OUT = 0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous reset, active low |
| fnSel | input | 3 | Function code |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| result | output | WIDTH | Operation result |
| carryOut | output | 1 | Carry (addition) or borrow (subtraction, decrement); 0 otherwise |
| zeroOut | output | 1 | Set when the result is zero |
| aGreater | output | 1 | Unsigned opA > opB |

## Verification
The bench builds the block with WIDTH = 4 and REG_OUT = 1. At that width, every combination of the eight function codes and the 256 operand pairs can be driven in 2048 cycles. This sweep covers the corner cases: every carry and borrow boundary, decrement of zero, NOT of all ones giving a zero flag, and equal operands for the comparison. Because the output register is enabled, the same sweep also checks the one-cycle latency and the reset values of the outputs.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_SUB  = 3'b001,
    FN_DEC  = 3'b010,
    FN_AND  = 3'b011,
    FN_OR   = 3'b100,
    FN_NOTA = 3'b101,
    FN_RSV6 = 3'b110,
    FN_RSV7 = 3'b111
  } aluFn_e;

  typedef struct packed {
    logic useAdder;  // result comes from the adder
    logic invB;      // feed ~opB to the adder
    logic onesB;     // feed all ones to the adder
    logic carryIn;   // adder carry in
    logic borrow;    // invert adder carry out into a borrow
    logic selAnd;
    logic selOr;
    logic selNot;
  } aluStrobes_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [2:0]  fnSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (aluFn_e'(fnSel))
      FN_ADD: strobes.useAdder = 1'b1;
      FN_SUB: begin
        strobes.useAdder = 1'b1;
        strobes.invB     = 1'b1;
        strobes.carryIn  = 1'b1;
        strobes.borrow   = 1'b1;
      end
      FN_DEC: begin
        strobes.useAdder = 1'b1;
        strobes.onesB    = 1'b1;
        strobes.borrow   = 1'b1;
      end
      FN_AND:  strobes.selAnd = 1'b1;
      FN_OR:   strobes.selOr  = 1'b1;
      FN_NOTA: strobes.selNot = 1'b1;
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] yNext,
  output logic             carryNext,
  output logic             zeroNext,
  output logic             gtNext
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] addendB;
  logic [SUM_W-1:0] sumFull;
  logic [WIDTH-1:0] logicBits;

  always_comb begin
    if (strobes.onesB)     addendB = '1;
    else if (strobes.invB) addendB = ~opB;
    else                   addendB = opB;
  end

  assign sumFull = {1'b0, opA} + {1'b0, addendB} + {{WIDTH{1'b0}}, strobes.carryIn};

  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_logicSlice
    always_comb begin
      if (strobes.selAnd)      logicBits[bitIdx] = opA[bitIdx] & opB[bitIdx];
      else if (strobes.selOr)  logicBits[bitIdx] = opA[bitIdx] | opB[bitIdx];
      else if (strobes.selNot) logicBits[bitIdx] = ~opA[bitIdx];
      else                     logicBits[bitIdx] = 1'b0;
    end
  end

  assign yNext     = strobes.useAdder ? sumFull[WIDTH-1:0] : logicBits;
  assign carryNext = strobes.useAdder & (sumFull[WIDTH] ^ strobes.borrow);
  assign zeroNext  = ~|yNext;
  assign gtNext    = opA > opB;

endmodule

// File: rtl/aluTop.sv
module aluTop
  import aluPkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       fnSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroOut,
  output logic             aGreater
);

  aluStrobes_t      strobes;
  logic [WIDTH-1:0] yNext;
  logic             carryNext;
  logic             zeroNext;
  logic             gtNext;

  aluCtrl u_ctrl (
    .fnSel   (fnSel),
    .strobes (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .yNext     (yNext),
    .carryNext (carryNext),
    .zeroNext  (zeroNext),
    .gtNext    (gtNext)
  );

  if (REG_OUT) begin : g_regOut
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        result   <= '0;
        carryOut <= 1'b0;
        zeroOut  <= 1'b1;
        aGreater <= 1'b0;
      end else begin
        result   <= yNext;
        carryOut <= carryNext;
        zeroOut  <= zeroNext;
        aGreater <= gtNext;
      end
    end
  end else begin : g_combOut
    assign result   = yNext;
    assign carryOut = carryNext;
    assign zeroOut  = zeroNext;
    assign aGreater = gtNext;
  end

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       fnSel,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             zeroOut,
  input logic             aGreater
);

  logic [2:0]       fnQ;
  logic [WIDTH-1:0] aQ;
  logic [WIDTH-1:0] bQ;
  logic             validQ;
  logic [2:0]       fnUse;
  logic [WIDTH-1:0] aUse;
  logic [WIDTH-1:0] bUse;
  logic             live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fnQ    <= '0;
      aQ     <= '0;
      bQ     <= '0;
      validQ <= 1'b0;
    end else begin
      fnQ    <= fnSel;
      aQ     <= opA;
      bQ     <= opB;
      validQ <= 1'b1;
    end
  end

  assign fnUse = REG_OUT ? fnQ : fnSel;
  assign aUse  = REG_OUT ? aQ  : opA;
  assign bUse  = REG_OUT ? bQ  : opB;
  assign live  = REG_OUT ? validQ : 1'b1;

  // R1
  a_r1_add_sum: assert property (@(posedge clk) disable iff (!rstN)
    (live && fnUse == 3'b000) |-> ({carryOut, result} == ({1'b0, aUse} + {1'b0, bUse})));

  // R7
  a_r7_unused_codes: assert property (@(posedge clk) disable iff (!rstN)
    (live && fnUse[2:1] == 2'b11) |-> (result == '0 && !carryOut && zeroOut));

  // R8
  a_r8_logic_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (live && (fnUse == 3'b011 || fnUse == 3'b100 || fnUse == 3'b101)) |-> !carryOut);

  // R9
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    zeroOut == (result == '0));

  // R10
  a_r10_compare: assert property (@(posedge clk) disable iff (!rstN)
    live |-> (aGreater == (aUse > bUse)));

  // R3
  a_r3_dec_borrow: assert property (@(posedge clk) disable iff (!rstN)
    (live && fnUse == 3'b010) |-> (carryOut == (aUse == '0)));

endmodule

bind aluTop aluChecker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_aluChecker (
  .clk      (clk),
  .rstN     (rstN),
  .fnSel    (fnSel),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .carryOut (carryOut),
  .zeroOut  (zeroOut),
  .aGreater (aGreater)
);

// File: tb/test_aluTop.sv
module test_aluTop;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  typedef struct {
    int fn;
    int y;
    int c;
    int z;
    int g;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   fnSel = '0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result;
  logic         carryOut;
  logic         zeroOut;
  logic         aGreater;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aluTop #(.WIDTH(W), .REG_OUT(1'b1)) i_aluTop (
    .clk      (clk),
    .rstN     (rstN),
    .fnSel    (fnSel),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .zeroOut  (zeroOut),
    .aGreater (aGreater)
  );

  function automatic string fnTag(int fn);
    case (fn)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4/R8";
      4: return "R5/R8";
      5: return "R6/R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: applies stimulus and pushes the expected outcome
  task automatic drive(int fn, int a, int b);
    expItem_t e;
    @(negedge clk);
    fnSel = 3'(fn);
    opA   = W'(a);
    opB   = W'(b);
    e.fn = fn;
    e.c  = 0;
    case (fn)
      0: begin e.y = (a + b) & MASK; e.c = (a + b > MASK) ? 1 : 0; end  // R1
      1: begin e.y = (a - b) & MASK; e.c = (b > a) ? 1 : 0; end         // R2
      2: begin e.y = (a - 1) & MASK; e.c = (a == 0) ? 1 : 0; end        // R3
      3: e.y = a & b;                                                   // R4
      4: e.y = a | b;                                                   // R5
      5: e.y = (~a) & MASK;                                             // R6
      default: e.y = 0;                                                 // R7
    endcase
    e.z = (e.y == 0) ? 1 : 0;   // R9
    e.g = (a > b) ? 1 : 0;      // R10
    expQ.push_back(e);
  endtask

  // monitor: outputs registered one edge after the drive (R11)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check({fnTag(e.fn), " result"}, int'(result), e.y);
        check({fnTag(e.fn), " carry"}, int'(carryOut), e.c);
        check("R9 zero", int'(zeroOut), e.z);
        check("R10 greater", int'(aGreater), e.g);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fnSel = 3'b000;
    opA   = 4'd9;
    opB   = 4'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset values held while rstN is low
    check("R11 reset result", int'(result), 0);
    check("R11 reset carry", int'(carryOut), 0);
    check("R11 reset zero", int'(zeroOut), 1);
    check("R11 reset greater", int'(aGreater), 0);
    rstN = 1'b1;
    for (int fn = 0; fn < 8; fn++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          drive(fn, a, b);
        end
      end
    end
    repeat (3) @(negedge clk);
    check("R11 queue drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule